// File: doc/BRIEF.md
# CIC DC Offset Remover

This block strips the DC level from a stream of signed fixed-point samples. It estimates the DC level with a two-section cascaded integrator-comb lowpass filter that runs at the sample rate and does not decimate. The filter's M-squared gain is then divided out, so the estimate has unity gain. The estimate is subtracted from a delayed copy of the input, and the difference is saturated back to the sample width.

Samples enter with a qualifying valid strobe and leave with one. Cycles without the strobe do not advance any filter state. The differential delay M is fixed when the block is built. With the I/Q option set, two identical lanes process the in-phase and quadrature parts independently. The filter itself contains no multiplier. When M is a power of two, gain compensation is an arithmetic shift. For any other M it is a rounded multiply by a fixed-point reciprocal.

Top module: `dc_cic_remover`

## Requirements
- R1: After reset, `valid_o` is low and `data_o` is zero until a sample has been accepted.
- R2: Each sample accepted with `valid_i` high produces exactly one `valid_o` pulse 5 clock edges later, counting the accepting edge. No `valid_o` pulse occurs without an earlier accepted sample.
- R3: The I lane output is `x[n] - floor(S/M^2)`, where `S` is the sum over k = 0..2M-2 of `w_k * x[n-k]` with `w_k = min(k+1, 2M-1-k)`. Samples before the first accepted one count as zero. For a power-of-two M, the division is exact and uses floor rounding.
- R4: Once a constant input has been applied for at least 2M-1 consecutive samples, the output is exactly zero.
- R5: Cycles with `valid_i` low change no filter state. The output sequence depends only on the accepted samples, whatever gaps lie between them.
- R6: The difference saturates to the signed sample range: to 2^(W-1)-1 above it and to -2^(W-1) below it.
- R7: With `IQ_EN` = 1, bits [W-1:0] carry lane I and bits [2W-1:W] carry lane Q on both data ports. Lane Q follows R3 on its own samples, independently of lane I.
- R8: Integrator overflow wraps in two's complement and cancels in the combs. A full-scale negative DC input held for hundreds of samples still gives an output of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample qualifier |
| data_i | input | LANES*DATA_W | Input samples, lane I in the low bits |
| valid_o | output | 1 | Output sample qualifier |
| data_o | output | LANES*DATA_W | DC-free samples, lane I in the low bits |

## Verification
Every output sample is due exactly 5 clock edges after the edge that accepted its input. This delay breaks down as two integrator registers, two comb registers and the saturating output register. The driver stamps each expected item with the cycle count at which the input was presented, and the monitor requires `valid_o` to appear when that count has advanced by 5. The monitor samples on the falling edge, so it reads settled values. Inputs with gaps between them are scored the same way, which exposes any state that moves on idle cycles. After the last input, the bench waits several cycles and checks that no expected item is still pending.

// File: rtl/dc_cic_pkg.sv
package dc_cic_pkg;
  function automatic int growth_bits(input int m);
    return 2 * $clog2(m);
  endfunction

  function automatic bit is_pow2(input int m);
    return (m > 0) && ((m & (m - 1)) == 0);
  endfunction
endpackage

// File: rtl/dc_cic_integ.sv
module dc_cic_integ #(
  parameter int ACC_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [ACC_W-1:0] in_i,
  output logic             vld_o,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;
  logic             vld_q;

  // modular accumulate; overflow cancels downstream in the combs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) acc_q <= acc_q + in_i;
    end
  end

  assign acc_o = acc_q;
  assign vld_o = vld_q;

  AST_INTEG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(acc_q)) else $error("integrator moved while idle"); // R5
endmodule

// File: rtl/dc_cic_comb.sv
module dc_cic_comb #(
  parameter int ACC_W = 22,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [ACC_W-1:0] in_i,
  output logic             vld_o,
  output logic [ACC_W-1:0] out_o
);
  logic [ACC_W-1:0] dly_q [DEPTH];
  logic [ACC_W-1:0] out_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) dly_q[k] <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        out_q    <= in_i - dly_q[DEPTH-1];
        dly_q[0] <= in_i;
        for (int k = 1; k < DEPTH; k++) dly_q[k] <= dly_q[k-1];
      end
    end
  end

  assign out_o = out_q;
  assign vld_o = vld_q;

  AST_COMB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(out_q) && $stable(dly_q[DEPTH-1])))
    else $error("comb moved while idle"); // R5
endmodule

// File: rtl/dc_cic_lane.sv
module dc_cic_lane
  import dc_cic_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DIFF_DELAY = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] x_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] y_o
);
  localparam int GROW  = growth_bits(DIFF_DELAY);
  localparam int ACC_W = DATA_W + GROW;
  localparam int XDLY  = 4;

  localparam logic signed [ACC_W-1:0] SAT_MAX = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_MIN = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic signed [ACC_W:0] EST_MAX =
    (ACC_W+1)'(DIFF_DELAY * DIFF_DELAY * ((2 ** (DATA_W-1)) - 1));
  localparam logic signed [ACC_W:0] EST_MIN =
    -((ACC_W+1)'(DIFF_DELAY * DIFF_DELAY * (2 ** (DATA_W-1))));

  logic [ACC_W-1:0] x_ext, i1, i2, c1, c2;
  logic             v1, v2, v3, v4;
  logic signed [ACC_W-1:0] est, diff;
  logic [DATA_W-1:0] x_pipe [XDLY];
  logic [DATA_W-1:0] y_q;
  logic              vld_q;

  assign x_ext = {{GROW{x_i[DATA_W-1]}}, x_i};

  dc_cic_integ #(.ACC_W(ACC_W)) u_integ1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i), .in_i(x_ext), .vld_o(v1), .acc_o(i1));
  dc_cic_integ #(.ACC_W(ACC_W)) u_integ2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(v1), .in_i(i1), .vld_o(v2), .acc_o(i2));
  dc_cic_comb #(.ACC_W(ACC_W), .DEPTH(DIFF_DELAY)) u_comb1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(v2), .in_i(i2), .vld_o(v3), .out_o(c1));
  dc_cic_comb #(.ACC_W(ACC_W), .DEPTH(DIFF_DELAY)) u_comb2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(v3), .in_i(c1), .vld_o(v4), .out_o(c2));

  // raw input delayed to line up with the estimate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < XDLY; k++) x_pipe[k] <= '0;
    end else begin
      x_pipe[0] <= x_i;
      for (int k = 1; k < XDLY; k++) x_pipe[k] <= x_pipe[k-1];
    end
  end

  // gain compensation by (1/M)^2
  if (is_pow2(DIFF_DELAY)) begin : g_shift
    assign est = $signed(c2) >>> GROW;
  end else begin : g_recip
    localparam int    FRAC   = DATA_W + 2 + GROW;
    localparam int    PW     = ACC_W + FRAC + 1;
    localparam longint MSQ   = longint'(DIFF_DELAY) * DIFF_DELAY;
    localparam longint RECIP = ((longint'(1) << FRAC) + MSQ / 2) / MSQ;
    logic signed [PW-1:0] prod;
    assign prod = $signed({{(FRAC+1){c2[ACC_W-1]}}, c2}) * $signed(PW'(RECIP))
                + $signed(PW'(longint'(1) << (FRAC-1)));
    assign est = prod[FRAC +: ACC_W];
  end

  assign diff = $signed({{GROW{x_pipe[XDLY-1][DATA_W-1]}}, x_pipe[XDLY-1]}) - est;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= v4;
      if (v4) begin
        if (diff > SAT_MAX)      y_q <= {1'b0, {(DATA_W-1){1'b1}}};
        else if (diff < SAT_MIN) y_q <= {1'b1, {(DATA_W-1){1'b0}}};
        else                     y_q <= diff[DATA_W-1:0];
      end
    end
  end

  assign y_o   = y_q;
  assign vld_o = vld_q;

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(vld_i, 5)) else $error("output without matching input"); // R2
  AST_EST_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v4 |-> ($signed({c2[ACC_W-1], c2}) <= EST_MAX && $signed({c2[ACC_W-1], c2}) >= EST_MIN))
    else $error("comb output outside scaled range"); // R8
endmodule

// File: rtl/dc_cic_remover.sv
module dc_cic_remover #(
  parameter int DATA_W     = 16,
  parameter int DIFF_DELAY = 8,
  parameter bit IQ_EN      = 1'b1
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  valid_i,
  input  logic [(IQ_EN ? 2 : 1)*DATA_W-1:0]     data_i,
  output logic                                  valid_o,
  output logic [(IQ_EN ? 2 : 1)*DATA_W-1:0]     data_o
);
  localparam int LANES = IQ_EN ? 2 : 1;

  logic [LANES-1:0] lane_vld;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dc_cic_lane #(.DATA_W(DATA_W), .DIFF_DELAY(DIFF_DELAY)) u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (valid_i),
      .x_i   (data_i[g*DATA_W +: DATA_W]),
      .vld_o (lane_vld[g]),
      .y_o   (data_o[g*DATA_W +: DATA_W])
    );
  end

  assign valid_o = &lane_vld;

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(valid_i, 5)) else $error("valid_o rose unprompted"); // R1
endmodule

// File: tb/dc_cic_remover_bench.sv
module dc_cic_remover_bench;
  localparam int W  = 16;
  localparam int M  = 8;
  localparam int SH = 2 * $clog2(M);
  localparam int NH = 2 * M - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [2*W-1:0] data_i = '0;
  logic valid_o;
  logic [2*W-1:0] data_o;

  int tests = 0, fails = 0, cyc = 0;
  int hist_i [NH];
  int hist_q [NH];
  int q_i[$], q_q[$], q_c[$];
  string q_t[$];

  dc_cic_remover #(.DATA_W(W), .DIFF_DELAY(M), .IQ_EN(1'b1)) u_dc_cic_remover (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .data_i(data_i),
    .valid_o(valid_o), .data_o(data_o));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int wgt(int k);
    return (k < M) ? k + 1 : NH - k;
  endfunction

  function automatic int clamp(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: present one sample and push its expected result (R3 model)
  task automatic send(input int a, input int b, input string tag);
    int si, sq;
    @(negedge clk);
    valid_i = 1'b1;
    data_i  = {16'(b), 16'(a)};
    for (int k = NH - 1; k > 0; k--) begin
      hist_i[k] = hist_i[k-1];
      hist_q[k] = hist_q[k-1];
    end
    hist_i[0] = a;
    hist_q[0] = b;
    si = 0; sq = 0;
    for (int k = 0; k < NH; k++) begin
      si += wgt(k) * hist_i[k];
      sq += wgt(k) * hist_q[k];
    end
    q_i.push_back(clamp(a - (si >>> SH)));
    q_q.push_back(clamp(b - (sq >>> SH)));
    q_c.push_back(cyc);
    q_t.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (q_i.size() == 0) begin
        check("R2 unexpected valid_o", 1, 0);
      end else begin
        int ei, eq, ec;
        string et;
        ei = q_i.pop_front();
        eq = q_q.pop_front();
        ec = q_c.pop_front();
        et = q_t.pop_front();
        check({"R2 latency (", et, ")"}, cyc, ec + 5);
        check({et, " lane I"}, int'($signed(data_o[W-1:0])), ei);
        check({"R7 lane Q (", et, ")"}, int'($signed(data_o[2*W-1:W])), eq);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < NH; k++) begin
      hist_i[k] = 0;
      hist_q[k] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check("R1 valid_o", int'(valid_o), 0);
    check("R1 data_o", int'(data_o), 0);
    idle(6);
    check("R1 valid_o idle", int'(valid_o), 0);

    // R3 / R7 / R5: varied values with idle gaps
    for (int n = 0; n < 40; n++) begin
      send(((n * 1237) % 4001) - 2000, 1500 - ((n * 311) % 3001), "R3");
      if (n % 5 == 4) idle(1 + n % 3); // R5 gaps
    end
    idle(3);
    // alternating pattern, back to back
    for (int n = 0; n < 20; n++) send((n % 2) ? 9000 : -9000, (n % 3) * 5000 - 4000, "R3");

    // R4: constant input settles to zero
    for (int n = 0; n < 30; n++) send(1000, -777, "R4");
    idle(2);

    // R6: saturation both ways
    for (int n = 0; n < 30; n++) send(-32768, 32767, "R6");
    for (int n = 0; n < 3; n++) send(32767, -32768, "R6");
    idle(8);
    tests++;
    if (int'($signed(data_o[W-1:0])) != 32767 || int'($signed(data_o[2*W-1:W])) != -32768) begin
      fails++;
      $display("FAIL R6 held outputs actual=%0d/%0d expected=32767/-32768",
               $signed(data_o[W-1:0]), $signed(data_o[2*W-1:W]));
    end

    // R8: long full-scale run forces integrator wrap
    for (int n = 0; n < 300; n++) send(-32768, -32768, "R8");
    idle(10);
    check("R8 final lane I", int'($signed(data_o[W-1:0])), 0);

    // R2: nothing left outstanding
    check("R2 pending items", q_i.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule